// File: doc/BRIEF.md
# PLL Clock Controller Register Block

This block is the digital side of a clock generator that can clock a system either straight from a crystal reference or from a PLL that multiplies that reference. Software reaches it through a small byte-wide register port: a two-bit address, a write strobe, a read strobe, write data and registered read data. Three registers are provided. The control register holds the lock-change flag, its interrupt enable, the PLL enable and the output clock select. The bandwidth register holds the gated lock status, the automatic-bandwidth and acquisition/tracking bits and a crystal-loss status. The programming register holds the multiplier and VCO range fields that go to the analog loop.

The block enforces the interlock between the PLL enable and the clock select so that the VCO can never be selected while the PLL is off. It also refuses new multiplier/range values while the PLL runs. The selected clock reaches the output through a glitch-free two-source switch and a divide-by-two stage. A stop request forces the selection back to the crystal. Lock and crystal-active arrive as plain inputs and are synchronised to the register clock. The analog VCO, phase detector and loop filter are outside this block.

Top module: `clkgen_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x2F, the bandwidth register (address 1) reads 0x00 while the crystal is active and unlocked, and the programming register (address 2) reads 0x66.
- R2: The programming register holds the multiplier in bits 7..4 and the range in bits 3..0, both driven out on `mult_o` and `range_o`. A write to it is ignored while PLL enable (control bit 5) is 1.
- R3: A programming write whose nibble is zero leaves that field at its previous value, so neither field ever holds 0.
- R4: Clock select (control bit 4) can only become 1 when PLL enable is 1 both before and after the write. PLL enable 0 together with clock select 1 is never reachable.
- R5: A control write that clears PLL enable while clock select is 1 leaves PLL enable at 1 and applies its other bits.
- R6: `clk_out` toggles on each rising edge of the selected source, so its period is twice the VCO period with clock select 1 and twice the crystal period with clock select 0.
- R7: The source switch is glitch-free: no `clk_out` level is shorter than one period of the faster source.
- R8: Bandwidth bit 6 is auto mode and bit 5 is acquisition/tracking, both writable. Bit 7 reads the synchronised lock input when auto is 1 and reads 0 otherwise. Bit 4 reads 1 when the crystal is not active. Bits 3..0 read 0.
- R9: In auto mode the lock flag (control bit 7, read-only) sets whenever the lock state is entered or left.
- R10: `irq_o` is 1 exactly when the flag, the interrupt enable (control bit 6) and auto mode are all 1.
- R11: The flag clears only on a control write that follows a control read which returned the flag as 1. A write without that read leaves the flag set.
- R12: A stop request clears clock select and returns `clk_out` to the crystal source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address (0 control, 1 bandwidth, 2 programming) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| xtal_clk | input | 1 | Crystal reference clock |
| vco_clk | input | 1 | VCO clock from the analog loop |
| lock_in | input | 1 | Lock detector output (asynchronous) |
| xtal_ok | input | 1 | Crystal active indication (asynchronous) |
| stop_req | input | 1 | Stop request, clears clock select |
| pll_en_o | output | 1 | PLL enable to the analog loop |
| vco_sel_o | output | 1 | Current clock select bit |
| mult_o | output | 4 | Multiplier value |
| range_o | output | 4 | VCO range value |
| irq_o | output | 1 | Lock-change interrupt request |
| clk_out | output | 1 | Divided output clock |

## Verification
The interlock is tried with every write pattern that tries a forbidden move: setting select and enable together from all-off, clearing enable while setting select, and clearing both from the running state. Each of these shows whether the two bits are checked against the current or the resulting value. The output clock is measured as a period after each change of source, which tells the crystal path from the VCO path. Its shortest level across the switches shows whether a switch leaks a glitch. The lock flag is driven through entering and leaving lock, flag clearing with and without the arming read, and manual mode. This separates the flag logic from the interrupt gating.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int FIELD_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_BW   = 2'd1,
    REG_PROG = 2'd2
  } reg_sel_e;

  // control register bit positions
  localparam int CTL_FLAG = 7;
  localparam int CTL_IE   = 6;
  localparam int CTL_PLL  = 5;
  localparam int CTL_SEL  = 4;

  // bandwidth register bit positions
  localparam int BW_LOCK = 7;
  localparam int BW_AUTO = 6;
  localparam int BW_ACQ  = 5;
  localparam int BW_XLOS = 4;

  localparam logic [FIELD_W-1:0] MUL_RST = 4'd6;
  localparam logic [FIELD_W-1:0] RNG_RST = 4'd6;
endpackage

// File: rtl/clkgen_sync.sv
`timescale 1ns/1ps
module clkgen_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkgen_regs.sv
`timescale 1ns/1ps
module clkgen_regs
  import clkgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic               rd,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               lock_s,
  input  logic               xtal_ok_s,
  input  logic               stop_req,
  output logic               pll_en,
  output logic               vco_sel,
  output logic [FIELD_W-1:0] mult,
  output logic [FIELD_W-1:0] range_val,
  output logic               irq
);
  logic flag_q, ie_q, pll_q, sel_q;
  logic auto_q, acq_q, lock_prev_q, arm_q;
  logic [FIELD_W-1:0] mul_q, rng_q;
  logic [DATA_W-1:0]  rdata_q;

  logic wr_ctl, wr_bw, wr_prog, rd_ctl;
  logic pll_nx, sel_nx, lock_edge, lock_view;
  logic [FIELD_W-1:0] mul_in, rng_in;

  assign wr_ctl  = wr && (addr == REG_CTRL);
  assign wr_bw   = wr && (addr == REG_BW);
  assign wr_prog = wr && (addr == REG_PROG);
  assign rd_ctl  = rd && (addr == REG_CTRL);

  assign lock_view = auto_q & lock_s;
  assign lock_edge = auto_q & (lock_s ^ lock_prev_q);

  // interlock: enable cannot drop under an active select,
  // select may rise only if enable is on now and stays on
  always_comb begin
    pll_nx = pll_q;
    sel_nx = sel_q;
    if (wr_ctl) begin
      pll_nx = wdata[CTL_PLL] | sel_q;
      sel_nx = wdata[CTL_SEL] & pll_q & pll_nx;
    end
    if (stop_req) sel_nx = 1'b0;
  end

  assign mul_in = wdata[DATA_W-1 -: FIELD_W];
  assign rng_in = wdata[FIELD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q      <= 1'b0;
      ie_q        <= 1'b0;
      pll_q       <= 1'b1;
      sel_q       <= 1'b0;
      auto_q      <= 1'b0;
      acq_q       <= 1'b0;
      lock_prev_q <= 1'b0;
      arm_q       <= 1'b0;
      mul_q       <= MUL_RST;
      rng_q       <= RNG_RST;
    end else begin
      pll_q       <= pll_nx;
      sel_q       <= sel_nx;
      lock_prev_q <= lock_s;
      if (wr_ctl) ie_q <= wdata[CTL_IE];
      if (wr_bw) begin
        auto_q <= wdata[BW_AUTO];
        acq_q  <= wdata[BW_ACQ];
      end
      if (lock_edge)            flag_q <= 1'b1;
      else if (wr_ctl && arm_q) flag_q <= 1'b0;
      if (wr_ctl)               arm_q <= 1'b0;
      else if (rd_ctl && flag_q) arm_q <= 1'b1;
      if (wr_prog && !pll_q) begin
        if (mul_in != '0) mul_q <= mul_in;
        if (rng_in != '0) rng_q <= rng_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd) begin
      case (addr)
        REG_CTRL: rdata_q <= {flag_q, ie_q, pll_q, sel_q, 4'hF};
        REG_BW:   rdata_q <= {lock_view, auto_q, acq_q, ~xtal_ok_s, 4'h0};
        REG_PROG: rdata_q <= {mul_q, rng_q};
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata     = rdata_q;
  assign pll_en    = pll_q;
  assign vco_sel   = sel_q;
  assign mult      = mul_q;
  assign range_val = rng_q;
  assign irq       = flag_q & ie_q & auto_q;
endmodule

// File: rtl/clkgen_clk_switch.sv
`timescale 1ns/1ps
module clkgen_clk_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic rst,
  input  logic xtal_clk,
  input  logic vco_clk,
  input  logic sel,
  output logic clk_out
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] src;
  logic [NSRC-1:0] en;
  logic            gclk;
  logic            div_q;

  assign src = {vco_clk, xtal_clk};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic want, want_s, en_q;
    // a source may start only after the other one has stopped
    assign want = ((sel ? 1 : 0) == i) & ~en[NSRC-1-i];

    clkgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(i == 0)) u_sync (
      .clk (src[i]),
      .rst (rst),
      .d   (want),
      .q   (want_s)
    );

    // enable changes only while this source is low
    always_ff @(negedge src[i]) begin
      if (rst) en_q <= (i == 0);
      else     en_q <= want_s;
    end

    assign en[i] = en_q;
  end

  assign gclk = |(src & en);

  always_ff @(posedge gclk) begin
    if (rst) div_q <= 1'b0;
    else     div_q <= ~div_q;
  end

  assign clk_out = div_q;
endmodule

// File: rtl/clkgen_ctrl.sv
`timescale 1ns/1ps
module clkgen_ctrl
  import clkgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               xtal_clk,
  input  logic               vco_clk,
  input  logic               lock_in,
  input  logic               xtal_ok,
  input  logic               stop_req,
  output logic               pll_en_o,
  output logic               vco_sel_o,
  output logic [FIELD_W-1:0] mult_o,
  output logic [FIELD_W-1:0] range_o,
  output logic               irq_o,
  output logic               clk_out
);
  logic lock_s, xtal_ok_s;

  clkgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock_sync (
    .clk (clk), .rst (rst), .d (lock_in), .q (lock_s)
  );

  clkgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_xtal_sync (
    .clk (clk), .rst (rst), .d (xtal_ok), .q (xtal_ok_s)
  );

  clkgen_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .rd        (bus_rd),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .lock_s    (lock_s),
    .xtal_ok_s (xtal_ok_s),
    .stop_req  (stop_req),
    .pll_en    (pll_en_o),
    .vco_sel   (vco_sel_o),
    .mult      (mult_o),
    .range_val (range_o),
    .irq       (irq_o)
  );

  clkgen_clk_switch #(.SYNC_STAGES(SYNC_STAGES)) u_switch (
    .rst      (rst),
    .xtal_clk (xtal_clk),
    .vco_clk  (vco_clk),
    .sel      (vco_sel_o),
    .clk_out  (clk_out)
  );
endmodule

// File: rtl/clkgen_ctrl_chk.sv
`timescale 1ns/1ps
module clkgen_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       stop_req,
  input logic       pll_en_o,
  input logic       vco_sel_o,
  input logic [3:0] mult_o,
  input logic [3:0] range_o
);
  assert_sel_needs_pll_R4: assert property (@(posedge clk) disable iff (rst)
    vco_sel_o |-> pll_en_o);

  assert_pll_held_R5: assert property (@(posedge clk) disable iff (rst)
    vco_sel_o |=> pll_en_o);

  assert_prog_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    pll_en_o |=> $stable({mult_o, range_o}));

  assert_no_zero_field_R3: assert property (@(posedge clk) disable iff (rst)
    (mult_o != 4'd0) && (range_o != 4'd0));

  assert_stop_clears_R12: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> !vco_sel_o);
endmodule

bind clkgen_ctrl clkgen_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .stop_req  (stop_req),
  .pll_en_o  (pll_en_o),
  .vco_sel_o (vco_sel_o),
  .mult_o    (mult_o),
  .range_o   (range_o)
);

// File: tb/clkgen_ctrl_bench.sv
`timescale 1ns/1ps
module clkgen_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       xtal_clk = 1'b0;
  logic       vco_clk = 1'b0;
  logic       lock_in = 1'b0;
  logic       xtal_ok = 1'b1;
  logic       stop_req = 1'b0;
  logic       pll_en_o, vco_sel_o, irq_o, clk_out;
  logic [3:0] mult_o, range_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5  clk = ~clk;
  always #20 xtal_clk = ~xtal_clk;
  always #6  vco_clk = ~vco_clk;

  clkgen_ctrl u_clkgen_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xtal_clk(xtal_clk),
    .vco_clk(vco_clk), .lock_in(lock_in), .xtal_ok(xtal_ok), .stop_req(stop_req),
    .pll_en_o(pll_en_o), .vco_sel_o(vco_sel_o), .mult_o(mult_o), .range_o(range_o),
    .irq_o(irq_o), .clk_out(clk_out)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // scoreboard of expected read data
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check(bus_rdata, 8'h00, "scoreboard-underflow");
      else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic period_chk(input real exp_ns, input string tag);
    realtime t0, t1;
    idle(60);
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out); t1 = $realtime;
    total++;
    if ((t1 - t0) < exp_ns - 0.5 || (t1 - t0) > exp_ns + 0.5) begin
      bad++;
      $display("FAIL %s actual=%0t expected=%0.1f ns", tag, t1 - t0, exp_ns);
    end
  endtask

  // shortest clk_out level after reset (R7)
  realtime last_edge = 0;
  realtime min_level = 1.0e9;
  bit      mon_on = 0;
  always @(clk_out) begin
    if (mon_on && (($realtime - last_edge) < min_level)) min_level = $realtime - last_edge;
    last_edge = $realtime;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(20);
    rst = 1'b0;
    idle(6);
    // R1 reset values
    rd_exp(2'd0, 8'h2F, "R1 ctrl reset");
    rd_exp(2'd1, 8'h00, "R1 bw reset");
    rd_exp(2'd2, 8'h66, "R1 prog reset");
    check({mult_o, range_o}, 8'h66, "R1 prog outputs");
    period_chk(80.0, "R6 crystal source after reset");
    @(posedge clk_out); mon_on = 1;

    // R2 write lock while PLL on
    wr_reg(2'd2, 8'h86);
    rd_exp(2'd2, 8'h66, "R2 prog ignored while on");
    wr_reg(2'd0, 8'h00);
    rd_exp(2'd0, 8'h0F, "R4 both off");
    wr_reg(2'd2, 8'h86);
    rd_exp(2'd2, 8'h86, "R2 prog accepted while off");
    check({mult_o, range_o}, 8'h86, "R2 prog outputs");
    // R3 zero nibbles keep old value
    wr_reg(2'd2, 8'h05);
    rd_exp(2'd2, 8'h85, "R3 zero multiplier kept");
    wr_reg(2'd2, 8'h70);
    rd_exp(2'd2, 8'h75, "R3 zero range kept");

    // R4 select interlock
    wr_reg(2'd0, 8'h10);
    rd_exp(2'd0, 8'h0F, "R4 select refused with pll off");
    wr_reg(2'd0, 8'h30);
    rd_exp(2'd0, 8'h2F, "R4 select refused in same write as enable");
    wr_reg(2'd0, 8'h10);
    rd_exp(2'd0, 8'h0F, "R4 select refused while enable drops");
    wr_reg(2'd0, 8'h20);
    wr_reg(2'd0, 8'h30);
    rd_exp(2'd0, 8'h3F, "R4 select accepted");
    wr_reg(2'd2, 8'h11);
    rd_exp(2'd2, 8'h75, "R2 prog ignored while vco runs");
    period_chk(24.0, "R6 vco source");

    // R5 enable held while select set
    wr_reg(2'd0, 8'h00);
    rd_exp(2'd0, 8'h2F, "R5 enable held");
    period_chk(80.0, "R6 back to crystal");

    // R12 stop request
    wr_reg(2'd0, 8'h30);
    period_chk(24.0, "R6 vco again");
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    rd_exp(2'd0, 8'h2F, "R12 stop clears select");
    period_chk(80.0, "R12 crystal after stop");

    // R8/R9/R10/R11 lock handling
    wr_reg(2'd1, 8'h40);
    rd_exp(2'd1, 8'h40, "R8 auto set unlocked");
    lock_in = 1'b1; idle(6);
    rd_exp(2'd1, 8'hC0, "R8 lock visible in auto");
    check({7'd0, irq_o}, 8'h00, "R10 irq off without enable");
    rd_exp(2'd0, 8'hAF, "R9 flag on lock entry");
    wr_reg(2'd0, 8'h60);
    rd_exp(2'd0, 8'h6F, "R11 flag cleared after read");
    lock_in = 1'b0; idle(6);
    check({7'd0, irq_o}, 8'h01, "R10 irq on leave");
    wr_reg(2'd0, 8'h60);
    check({7'd0, irq_o}, 8'h01, "R11 write without read keeps flag");
    rd_exp(2'd0, 8'hEF, "R9 flag on lock exit");
    wr_reg(2'd1, 8'h20);
    check({7'd0, irq_o}, 8'h00, "R10 irq masked in manual");
    lock_in = 1'b1; idle(6);
    rd_exp(2'd1, 8'h20, "R8 lock reads 0 in manual");
    wr_reg(2'd0, 8'h20);
    rd_exp(2'd0, 8'h2F, "R11 flag cleared after arming read");
    xtal_ok = 1'b0; idle(6);
    rd_exp(2'd1, 8'h30, "R8 crystal loss bit");
    xtal_ok = 1'b1; idle(6);
    rd_exp(2'd1, 8'h20, "R8 crystal loss clears");

    idle(10);
    total++;
    if (min_level < 11.5) begin
      bad++;
      $display("FAIL R7 glitch actual=%0t expected>=12 ns", min_level);
    end
    check(8'(exp_q.size()), 8'h00, "scoreboard drained");
    finish_run();
  end
endmodule